// File: doc/BRIEF.md
# Multi-level DMA channel arbiter

The arbiter chooses one DMA channel per clock from up to 32 channels. Each channel presents a pending request and a 2-bit priority level. Levels are compared first, and a higher level always wins. Inside the winning level the choice is either fixed (lowest channel number first) or rotating, and each level selects its own scheme. The result is registered and presented one clock later as a channel number, a valid strobe and the quality-of-service code configured for the winning level.

All configuration sits in one 32-bit control word, with one byte per level. Byte n occupies bits [8n+7:8n]. Bit 7 of a byte enables rotation. Bits 6:5 hold the quality-of-service code: 0 is background, 1 is bandwidth-sensitive, 2 is latency-sensitive and 3 is critical. Bits 4:0 hold the last-granted channel of that level. Software can read the word and write it whole. A protection input blocks writes. In rotating mode the hardware updates the last-granted field on each grant at that level, and software may move the field to steer where the next search begins.

Top module: `dma_level_arb`

## Requirements
- R1: After reset the control word reads 0x40404040 and grant_valid_o is 0.
- R2: A grant always goes to a pending channel at the highest level that has any pending request. The level of channel c is ch_lvl_i[2c+1:2c].
- R3: With bit 7 of the winning level's byte at 0, the lowest-numbered pending channel of that level wins, whatever value bits 4:0 of that byte hold.
- R4: With bit 7 of the winning level's byte at 1, the search begins at the channel after the value in bits 4:0 and wraps from 31 to 0.
- R5: A grant at a rotating level writes the granted channel number into bits 4:0 of that level's byte. A grant at a static level leaves those bits unchanged.
- R6: The grant is registered. Requests sampled at one clock edge give grant_valid_o, grant_ch_o and grant_qos_o after that edge, and grant_qos_o equals bits 6:5 of the winning level's byte as it stood at the sampling edge.
- R7: With no request pending at an edge, grant_valid_o is 0 after that edge.
- R8: A write presented while reg_wprot_i is 1 leaves the control word unchanged.
- R9: Clearing bit 7 of a level through a write that keeps bits 4:0 does not change bits 4:0. Later static grants do not change them either.
- R10: When a write and a rotating grant fall on the same edge, the written word is stored whole. That edge's arbitration uses the old pointer, and the next arbitration uses the written one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 32 | Pending request, one bit per channel |
| ch_lvl_i | input | 64 | Priority level of each channel, 2 bits per channel |
| reg_we_i | input | 1 | Control word write strobe |
| reg_wprot_i | input | 1 | Write protection; when high, writes are dropped |
| reg_wdata_i | input | 32 | Control word write data |
| reg_rdata_o | output | 32 | Current control word |
| grant_valid_o | output | 1 | A channel was granted |
| grant_ch_o | output | 5 | Granted channel number |
| grant_qos_o | output | 2 | Quality-of-service code of the winning level |

## Verification
A software write and a hardware update of a rotating level's pointer can land on the same edge. The bench provokes this by writing a new pointer while requests are pending at a rotating level. It judges the result by checking three things: the grant came from the old pointer, the stored word equals the written data, and the following grant starts from the written pointer. A random phase mixes writes, protection and changing levels so that the collision also occurs unplanned, and a behavioural model compares every output on every clock.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int CFG_W   = 8;
  localparam int LAST_W  = 5;
  localparam int QOS_W   = 2;
  localparam int QOS_LSB = 5;
  localparam int RR_BIT  = 7;

  typedef enum logic [QOS_W-1:0] {
    QOS_BG   = 2'd0,
    QOS_BW   = 2'd1,
    QOS_LAT  = 2'd2,
    QOS_CRIT = 2'd3
  } qos_e;

  // bit layout matches the per-level control byte: [7] rr, [6:5] qos, [4:0] last
  typedef struct packed {
    logic              rr_en;
    qos_e              qos;
    logic [LAST_W-1:0] last;
  } lvl_cfg_t;

  localparam lvl_cfg_t CFG_RST = '{rr_en: 1'b0, qos: QOS_LAT, last: '0};
endpackage

// File: rtl/dma_arb_lvl_split.sv
module dma_arb_lvl_split #(
  parameter  int NUM_CH  = 32,
  parameter  int NUM_LVL = 4,
  localparam int LVL_W   = $clog2(NUM_LVL)
) (
  input  logic [NUM_CH-1:0]               req_i,
  input  logic [NUM_CH*LVL_W-1:0]         ch_lvl_i,
  output logic [NUM_LVL-1:0][NUM_CH-1:0]  lvl_req_o,
  output logic [LVL_W-1:0]                top_lvl_o,
  output logic                            any_o
);
  always_comb begin
    for (int l = 0; l < NUM_LVL; l++) begin
      for (int c = 0; c < NUM_CH; c++) begin
        lvl_req_o[l][c] = req_i[c] && (ch_lvl_i[c*LVL_W +: LVL_W] == LVL_W'(l));
      end
    end
  end

  // ascending scan: highest level with a request ends up selected
  always_comb begin
    top_lvl_o = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (|lvl_req_o[l]) top_lvl_o = LVL_W'(l);
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/dma_arb_pick.sv
module dma_arb_pick
  import dma_arb_pkg::*;
#(
  parameter  int NUM_CH = 32,
  localparam int CH_W   = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] req_i,
  input  logic              rr_en_i,
  input  logic [LAST_W-1:0] last_i,
  output logic              hit_o,
  output logic [CH_W-1:0]   ch_o
);
  int start;
  int idx;

  always_comb begin
    if (rr_en_i && (int'(last_i) < NUM_CH - 1)) start = int'(last_i) + 1;
    else                                         start = 0;
  end

  always_comb begin
    hit_o = 1'b0;
    ch_o  = '0;
    idx   = 0;
    for (int k = 0; k < NUM_CH; k++) begin
      idx = start + k;
      if (idx >= NUM_CH) idx = idx - NUM_CH;
      if (!hit_o && req_i[idx]) begin
        hit_o = 1'b1;
        ch_o  = CH_W'(idx);
      end
    end
  end
endmodule

// File: rtl/dma_arb_cfg_reg.sv
module dma_arb_cfg_reg
  import dma_arb_pkg::*;
#(
  parameter  int NUM_CH  = 32,
  parameter  int NUM_LVL = 4,
  localparam int CH_W    = $clog2(NUM_CH),
  localparam int LVL_W   = $clog2(NUM_LVL),
  localparam int REG_W   = NUM_LVL * CFG_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic                       wprot_i,
  input  logic [REG_W-1:0]           wdata_i,
  input  logic                       upd_i,
  input  logic [LVL_W-1:0]           upd_lvl_i,
  input  logic [CH_W-1:0]            upd_ch_i,
  output lvl_cfg_t [NUM_LVL-1:0]     cfg_o,
  output logic [REG_W-1:0]           rdata_o
);
  typedef lvl_cfg_t [NUM_LVL-1:0] cfg_arr_t;

  cfg_arr_t cfg_q;

  // software write wins over a same-cycle pointer update
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= {NUM_LVL{CFG_RST}};
    end else if (we_i && !wprot_i) begin
      cfg_q <= cfg_arr_t'(wdata_i);
    end else if (upd_i) begin
      cfg_q[upd_lvl_i].last <= LAST_W'(upd_ch_i);
    end
  end

  assign cfg_o   = cfg_q;
  assign rdata_o = REG_W'(cfg_q);
endmodule

// File: rtl/dma_level_arb.sv
module dma_level_arb
  import dma_arb_pkg::*;
#(
  parameter  int NUM_CH  = 32,
  parameter  int NUM_LVL = 4,
  localparam int CH_W    = $clog2(NUM_CH),
  localparam int LVL_W   = $clog2(NUM_LVL),
  localparam int REG_W   = NUM_LVL * CFG_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_CH-1:0]         req_i,
  input  logic [NUM_CH*LVL_W-1:0]   ch_lvl_i,
  input  logic                      reg_we_i,
  input  logic                      reg_wprot_i,
  input  logic [REG_W-1:0]          reg_wdata_i,
  output logic [REG_W-1:0]          reg_rdata_o,
  output logic                      grant_valid_o,
  output logic [CH_W-1:0]           grant_ch_o,
  output logic [QOS_W-1:0]          grant_qos_o
);
  logic [NUM_LVL-1:0][NUM_CH-1:0] lvl_req;
  logic [LVL_W-1:0]               top_lvl;
  logic                           any_req;
  lvl_cfg_t [NUM_LVL-1:0]         cfg;
  logic [NUM_LVL-1:0]             pick_hit;
  logic [NUM_LVL-1:0][CH_W-1:0]   pick_ch;
  logic                           win_valid;
  logic [CH_W-1:0]                win_ch;
  logic                           ptr_upd;

  dma_arb_lvl_split #(.NUM_CH(NUM_CH), .NUM_LVL(NUM_LVL)) u_split (
    .req_i     (req_i),
    .ch_lvl_i  (ch_lvl_i),
    .lvl_req_o (lvl_req),
    .top_lvl_o (top_lvl),
    .any_o     (any_req)
  );

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    dma_arb_pick #(.NUM_CH(NUM_CH)) u_pick (
      .req_i   (lvl_req[l]),
      .rr_en_i (cfg[l].rr_en),
      .last_i  (cfg[l].last),
      .hit_o   (pick_hit[l]),
      .ch_o    (pick_ch[l])
    );
  end

  assign win_valid = any_req && pick_hit[top_lvl];
  assign win_ch    = pick_ch[top_lvl];
  assign ptr_upd   = win_valid && cfg[top_lvl].rr_en;

  dma_arb_cfg_reg #(.NUM_CH(NUM_CH), .NUM_LVL(NUM_LVL)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .wprot_i   (reg_wprot_i),
    .wdata_i   (reg_wdata_i),
    .upd_i     (ptr_upd),
    .upd_lvl_i (top_lvl),
    .upd_ch_i  (win_ch),
    .cfg_o     (cfg),
    .rdata_o   (reg_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_valid_o <= 1'b0;
      grant_ch_o    <= '0;
      grant_qos_o   <= '0;
    end else begin
      grant_valid_o <= win_valid;
      if (win_valid) begin
        grant_ch_o  <= win_ch;
        grant_qos_o <= cfg[top_lvl].qos;
      end
    end
  end
endmodule

// File: rtl/dma_level_arb_chk.sv
module dma_level_arb_chk
  import dma_arb_pkg::*;
#(
  parameter  int NUM_CH  = 32,
  parameter  int NUM_LVL = 4,
  localparam int CH_W    = $clog2(NUM_CH),
  localparam int LVL_W   = $clog2(NUM_LVL),
  localparam int REG_W   = NUM_LVL * CFG_W
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [NUM_CH-1:0]       req_i,
  input logic [NUM_CH*LVL_W-1:0] ch_lvl_i,
  input logic                    reg_we_i,
  input logic                    reg_wprot_i,
  input logic [REG_W-1:0]        reg_wdata_i,
  input logic [REG_W-1:0]        reg_rdata_o,
  input logic                    grant_valid_o,
  input logic [CH_W-1:0]         grant_ch_o,
  input logic [QOS_W-1:0]        grant_qos_o
);
  logic [NUM_CH-1:0]       req_d;
  logic [NUM_CH*LVL_W-1:0] lvl_d;
  logic [REG_W-1:0]        reg_d;
  logic [LVL_W-1:0]        max_lvl;
  logic [LVL_W-1:0]        g_lvl;
  logic [QOS_W-1:0]        exp_qos;
  logic [REG_W-1:0]        cfg_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_d <= '0;
      lvl_d <= '0;
      reg_d <= {NUM_LVL{CFG_RST}};
    end else begin
      req_d <= req_i;
      lvl_d <= ch_lvl_i;
      reg_d <= reg_rdata_o;
    end
  end

  always_comb begin
    max_lvl = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (req_d[c] && (lvl_d[c*LVL_W +: LVL_W] > max_lvl)) max_lvl = lvl_d[c*LVL_W +: LVL_W];
    end
  end

  always_comb begin
    cfg_mask = '1;
    for (int l = 0; l < NUM_LVL; l++) cfg_mask[l*CFG_W +: LAST_W] = '0;
  end

  assign g_lvl   = lvl_d[int'(grant_ch_o)*LVL_W +: LVL_W];
  assign exp_qos = reg_d[int'(g_lvl)*CFG_W + QOS_LSB +: QOS_W];

  AST_GRANT_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o |-> req_d[grant_ch_o]); // R2
  AST_GRANT_TOP_LVL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o |-> (g_lvl == max_lvl)); // R2
  AST_QOS_OF_LVL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o |-> (grant_qos_o == exp_qos)); // R6
  AST_IDLE_NO_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|req_d) |-> !grant_valid_o); // R7
  AST_WPROT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_wprot_i) |=> ((reg_rdata_o & cfg_mask) == ($past(reg_rdata_o) & cfg_mask))); // R8
  AST_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !reg_wprot_i) |=> (reg_rdata_o == $past(reg_wdata_i))); // R10

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_keep
    AST_STATIC_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!(reg_we_i && !reg_wprot_i) && !reg_rdata_o[l*CFG_W + RR_BIT])
        |=> $stable(reg_rdata_o[l*CFG_W +: LAST_W])); // R5
  end
endmodule

bind dma_level_arb dma_level_arb_chk #(.NUM_CH(NUM_CH), .NUM_LVL(NUM_LVL)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_i         (req_i),
  .ch_lvl_i      (ch_lvl_i),
  .reg_we_i      (reg_we_i),
  .reg_wprot_i   (reg_wprot_i),
  .reg_wdata_i   (reg_wdata_i),
  .reg_rdata_o   (reg_rdata_o),
  .grant_valid_o (grant_valid_o),
  .grant_ch_o    (grant_ch_o),
  .grant_qos_o   (grant_qos_o)
);

// File: tb/dma_level_arb_bench.sv
`timescale 1ns/1ps
module dma_level_arb_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] req = '0;
  logic [63:0] lvl = '0;
  logic        we = 1'b0;
  logic        wprot = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        gvalid;
  logic [4:0]  gch;
  logic [1:0]  gqos;

  int checks = 0;
  int errors = 0;
  logic [31:0] mdl = 32'h4040_4040;

  always #2.5 clk = ~clk;

  dma_level_arb u_dma_level_arb (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .req_i         (req),
    .ch_lvl_i      (lvl),
    .reg_we_i      (we),
    .reg_wprot_i   (wprot),
    .reg_wdata_i   (wdata),
    .reg_rdata_o   (rdata),
    .grant_valid_o (gvalid),
    .grant_ch_o    (gch),
    .grant_qos_o   (gqos)
  );

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic int lvl_of(input int c);
    return int'(lvl[c*2 +: 2]);
  endfunction

  // one clock: model predicts, design steps, outputs compared at the next falling edge
  task automatic cycle(input string tag);
    int best = -1;
    int win = -1;
    logic rr;
    int last;
    logic [1:0] eq;
    logic [31:0] nxt;
    for (int c = 0; c < 32; c++)
      if (req[c] && lvl_of(c) > best) best = lvl_of(c);
    eq = '0;
    rr = 1'b0;
    if (best >= 0) begin
      rr   = mdl[best*8 + 7];
      last = int'(mdl[best*8 +: 5]);
      eq   = mdl[best*8 + 5 +: 2];
      if (rr) begin
        for (int k = 1; k <= 32; k++)
          if (win < 0 && req[(last + k) % 32] && lvl_of((last + k) % 32) == best) win = (last + k) % 32;
      end else begin
        for (int c = 0; c < 32; c++)
          if (win < 0 && req[c] && lvl_of(c) == best) win = c;
      end
    end
    nxt = mdl;
    if (win >= 0 && rr) nxt[best*8 +: 5] = 5'(win);
    if (we && !wprot) nxt = wdata;
    @(posedge clk);
    @(negedge clk);
    check(tag, "grant_valid", 32'(gvalid), 32'(win >= 0));
    if (win >= 0) begin
      check(tag, "grant_ch", 32'(gch), 32'(win));
      check(tag, "grant_qos", 32'(gqos), 32'(eq));
    end
    check(tag, "ctrl_word", rdata, nxt);
    mdl = nxt;
  endtask

  task automatic wr(input string tag, input logic [31:0] d);
    we = 1'b1; wdata = d;
    cycle(tag);
    we = 1'b0;
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "reset ctrl_word", rdata, 32'h4040_4040);
    check("R1", "reset grant_valid", 32'(gvalid), 32'd0);

    cycle("R7");
    cycle("R7");

    // levels: ch5 at 3, ch2 at 1, ch9 at 0; level 3 qos critical
    wr("R6", 32'h6040_4040);
    lvl[5*2 +: 2] = 2'd3; lvl[2*2 +: 2] = 2'd1; lvl[9*2 +: 2] = 2'd0;
    req = (32'd1 << 5) | (32'd1 << 2) | (32'd1 << 9);
    cycle("R2");
    cycle("R6");
    req = (32'd1 << 2) | (32'd1 << 9);
    cycle("R2");
    req = (32'd1 << 9);
    cycle("R6");
    req = '0; lvl = '0;
    cycle("R7");

    // static level 0 with non-zero pointer
    wr("R3", 32'h4040_4051);
    req = (32'd1 << 3) | (32'd1 << 20);
    cycle("R3");
    cycle("R3");
    req = '0;

    // rotating level 0 from pointer 17
    wr("R4", 32'h4040_40D1);
    req = (32'd1 << 3) | (32'd1 << 20);
    cycle("R4");
    cycle("R5");
    cycle("R4");
    req = '0;
    wr("R4", 32'h4040_40DE);
    req = (32'd1 << 31) | 32'd1;
    cycle("R4");
    cycle("R5");
    req = '0;

    // leave rotation, pointer must survive static grants
    wr("R9", rdata & ~32'h0000_0080);
    req = (32'd1 << 31) | 32'd1;
    cycle("R9");
    cycle("R9");
    req = '0;
    cycle("R9");

    // protected write dropped
    wprot = 1'b1;
    wr("R8", 32'h0000_0000);
    wr("R8", 32'hFFFF_FFFF);
    wprot = 1'b0;
    cycle("R8");

    // write and rotating grant on the same edge
    wr("R10", 32'h4040_40C0);
    req = (32'd1 << 3) | (32'd1 << 20);
    wr("R10", 32'h4040_40C5);
    cycle("R10");
    cycle("R10");
    req = '0;

    // mixed random traffic
    for (int i = 0; i < 600; i++) begin
      req   = $urandom() & $urandom();
      lvl   = {$urandom(), $urandom()};
      wprot = ($urandom() % 4) == 0;
      we    = ($urandom() % 6) == 0;
      wdata = $urandom();
      cycle("R2");
    end
    we = 1'b0; wprot = 1'b0; req = '0;
    cycle("R7");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule